// File: doc/BRIEF.md
# Bit-Aliased Dual-Port Marker Memory

This block holds the marker variables of a control processor. It stores 128 double words of 32 bits. The first two double words can also be reached one bit at a time. Bit markers are not a separate store. Each one is a bit of a double word, so writing a bit through either port changes the word that holds it. Writing a whole word changes every bit that aliases it. No masking in software is needed.

Two ports reach the same array in the same clock cycle:
- The word port moves 32-bit data.
- The bit port moves a single bit.

Both ports take an 8-bit address, write data, a write enable and a read enable. The top address bit picks the view:
- 0 selects the double-word view, and the lower seven bits index one of 128 words.
- 1 selects the bit view, and the lower bits select a bit of one of the two aliased words.

The word port can also carry a single bit. When it reads a bit, the bit appears in the least significant position of the output. When it writes a bit, the value comes from the least significant bit of the write data.

Top module: `marker_mem`

## Requirements
- R1: A synchronous active-high reset clears every stored word and both read outputs to zero.
- R2: In the word view (address bit 7 = 0), a word-port write stores all 32 bits of the write data into double word addr[6:0]. A word-port read returns that word one clock after the edge that samples it.
- R3: In the bit view (address bit 7 = 1, bit 6 = 0), addr[5] selects double word 0 or 1 and addr[4:0] selects the bit inside it. A bit-port write changes only that bit, and the change is visible through the word view.
- R4: A word-port access in the bit view reads the selected bit into rdata[0] with rdata[31:1] = 0. A word-port write in the bit view stores wdata[0] into that single bit only.
- R5: Bit-view addresses with address bit 6 = 1 read as 0 on either port, and writes to them change nothing.
- R6: A bit-port access in the word view reaches bit 0 of double word addr[6:0]. Reads return that bit, and writes change only that bit.
- R7: A read output changes only at an edge where its read enable is high. Otherwise it holds its last value.
- R8: A read and a write to the same location at the same edge return the contents from before the write.
- R9: When both ports write the same double word at one edge, both writes take effect. Where they target the same bit, the bit-port value wins.
- R10: The two ports may access different double words at one edge, and both accesses complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| w_addr | input | 8 | Word-port address; bit 7 selects the view |
| w_wdata | input | 32 | Word-port write data (bit 0 only in the bit view) |
| w_we | input | 1 | Word-port write enable |
| w_re | input | 1 | Word-port read enable |
| w_rdata | output | 32 | Word-port read data, registered |
| b_addr | input | 8 | Bit-port address; bit 7 selects the view |
| b_wdata | input | 1 | Bit-port write data |
| b_we | input | 1 | Bit-port write enable |
| b_re | input | 1 | Bit-port read enable |
| b_rdata | output | 1 | Bit-port read data, registered |

## Verification
The case that matters most is both ports writing the same double word at one edge. One port writes the whole word while the other writes one of its bits. The bench drives both ports in one cycle, in one case with the bit aimed at a word bit that the word write sets and in another at a bit it clears. It then reads the word back and expects the word-port value everywhere except the addressed bit, which must carry the bit-port value. The same-cycle read-and-write case on one location is also provoked, and the bench expects the value from before the write.

// File: rtl/mm_pkg.sv
package mm_pkg;
    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 32;
    localparam int IDX_W       = ADDR_W - 1;
    localparam int WORDS       = 1 << IDX_W;
    localparam int BSEL_W      = $clog2(DATA_W);
    localparam int ALIAS_WORDS = 2;
    localparam int ALIAS_W     = $clog2(ALIAS_WORDS);

    typedef enum logic {VIEW_WORD = 1'b0, VIEW_BIT = 1'b1} view_e;

    typedef struct packed {
        view_e             view;
        logic              in_range;
        logic [IDX_W-1:0]  widx;
        logic [BSEL_W-1:0] bsel;
    } maddr_t;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] data;
    } wlane_t;

    function automatic maddr_t decode(input logic [ADDR_W-1:0] a);
        maddr_t d;
        d.view = view_e'(a[ADDR_W-1]);
        if (d.view == VIEW_BIT) begin
            d.widx     = IDX_W'(a[BSEL_W +: ALIAS_W]);
            d.bsel     = a[BSEL_W-1:0];
            d.in_range = ((a[IDX_W-1:0] >> (BSEL_W + ALIAS_W)) == '0);
        end else begin
            d.widx     = a[IDX_W-1:0];
            d.bsel     = '0;
            d.in_range = 1'b1;
        end
        return d;
    endfunction
endpackage

// File: rtl/mm_decode.sv
module mm_decode
    import mm_pkg::*;
#(
    parameter bit WORD_LANE = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    output maddr_t            dec,
    output wlane_t            lane
);
    logic [DATA_W-1:0] one_hot;

    always_comb begin
        dec     = decode(addr);
        one_hot = DATA_W'(1) << dec.bsel;
    end

    generate
        if (WORD_LANE) begin : g_word
            always_comb begin
                lane.en   = we && dec.in_range;
                lane.idx  = dec.widx;
                lane.mask = (dec.view == VIEW_WORD) ? '1 : one_hot;
                lane.data = (dec.view == VIEW_WORD) ? wdata : {DATA_W{wdata[0]}};
            end
        end else begin : g_bit
            always_comb begin
                lane.en   = we && dec.in_range;
                lane.idx  = dec.widx;
                lane.mask = one_hot;
                lane.data = {DATA_W{wdata[0]}};
            end
        end
    endgenerate
endmodule

// File: rtl/mm_store.sv
module mm_store
    import mm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wlane_t            lane_w,
    input  wlane_t            lane_b,
    input  logic [IDX_W-1:0]  ridx_w,
    input  logic [IDX_W-1:0]  ridx_b,
    output logic [DATA_W-1:0] q_w,
    output logic [DATA_W-1:0] q_b
);
    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] nxt [WORDS];

    generate
        for (genvar i = 0; i < WORDS; i++) begin : g_cell
            always_comb begin
                nxt[i] = mem[i];
                if (lane_w.en && lane_w.idx == IDX_W'(i))
                    nxt[i] = (nxt[i] & ~lane_w.mask) | (lane_w.data & lane_w.mask);
                if (lane_b.en && lane_b.idx == IDX_W'(i))
                    nxt[i] = (nxt[i] & ~lane_b.mask) | (lane_b.data & lane_b.mask);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) mem <= '{default: '0};
        else     mem <= nxt;
    end

    assign q_w = mem[ridx_w];
    assign q_b = mem[ridx_b];

    // R9: bit-lane bits land last, so they always show after the edge
    p_bit_lane_wins_r9: assert property (@(posedge clk) disable iff (rst)
        lane_b.en |=> (((mem[$past(lane_b.idx)] ^ $past(lane_b.data)) & $past(lane_b.mask)) == '0));

    // R2 / R10: word-lane bits land unless the bit lane hits the same word
    p_word_lane_r2: assert property (@(posedge clk) disable iff (rst)
        (lane_w.en && !(lane_b.en && lane_b.idx == lane_w.idx))
        |=> (((mem[$past(lane_w.idx)] ^ $past(lane_w.data)) & $past(lane_w.mask)) == '0));
endmodule

// File: rtl/mm_rdport.sv
module mm_rdport
    import mm_pkg::*;
#(
    parameter int OUT_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              re,
    input  maddr_t            dec,
    input  logic [DATA_W-1:0] q,
    output logic [OUT_W-1:0]  rdata
);
    logic [OUT_W-1:0] fmt;

    always_comb begin
        if (dec.view == VIEW_BIT) fmt = OUT_W'(dec.in_range & q[dec.bsel]);
        else                      fmt = q[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= fmt;
    end

    // R7: output only moves on an enabled read
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !re |=> $stable(rdata));
endmodule

// File: rtl/marker_mem.sv
module marker_mem
    import mm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] w_addr,
    input  logic [DATA_W-1:0] w_wdata,
    input  logic              w_we,
    input  logic              w_re,
    output logic [DATA_W-1:0] w_rdata,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_wdata,
    input  logic              b_we,
    input  logic              b_re,
    output logic              b_rdata
);
    maddr_t            dec_w, dec_b;
    wlane_t            lane_w, lane_b;
    logic [DATA_W-1:0] q_w, q_b;

    mm_decode #(.WORD_LANE(1'b1)) u_dec_w (
        .addr(w_addr), .wdata(w_wdata), .we(w_we), .dec(dec_w), .lane(lane_w));

    mm_decode #(.WORD_LANE(1'b0)) u_dec_b (
        .addr(b_addr), .wdata(DATA_W'(b_wdata)), .we(b_we), .dec(dec_b), .lane(lane_b));

    mm_store u_store (
        .clk(clk), .rst(rst), .lane_w(lane_w), .lane_b(lane_b),
        .ridx_w(dec_w.widx), .ridx_b(dec_b.widx), .q_w(q_w), .q_b(q_b));

    mm_rdport #(.OUT_W(DATA_W)) u_rd_w (
        .clk(clk), .rst(rst), .re(w_re), .dec(dec_w), .q(q_w), .rdata(w_rdata));

    mm_rdport #(.OUT_W(1)) u_rd_b (
        .clk(clk), .rst(rst), .re(b_re), .dec(dec_b), .q(q_b), .rdata(b_rdata));

    // R4: bit-view read through the word port leaves the upper bits clear
    p_bitview_upper_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (w_re && w_addr[ADDR_W-1]) |=> (w_rdata[DATA_W-1:1] == '0));

    // R5: bit addresses past the aliased words read as zero
    p_range_rd_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (b_re && b_addr[ADDR_W-1] && b_addr[IDX_W-1]) |=> (b_rdata == 1'b0));
endmodule

// File: tb/test_marker_mem.sv
module test_marker_mem;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  w_addr, b_addr;
    logic [31:0] w_wdata, w_rdata;
    logic        w_we, w_re, b_wdata, b_we, b_re, b_rdata;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    marker_mem i_marker_mem (.*);

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cyc(input logic [7:0] wa, input logic [31:0] wd, input logic wwe, wre,
                       input logic [7:0] ba, input logic bd, input logic bwe, bre);
        w_addr = wa; w_wdata = wd; w_we = wwe; w_re = wre;
        b_addr = ba; b_wdata = bd; b_we = bwe; b_re = bre;
        @(posedge clk); #1;
        w_we = 0; w_re = 0; b_we = 0; b_re = 0;
    endtask

    task automatic wr_word(input logic [7:0] a, input logic [31:0] d);
        cyc(a, d, 1, 0, 8'h00, 0, 0, 0);
    endtask

    task automatic rd_word(input logic [7:0] a, output logic [31:0] d);
        cyc(a, 32'h0, 0, 1, 8'h00, 0, 0, 0);
        d = w_rdata;
    endtask

    task automatic rd_bit(input logic [7:0] a, output logic d);
        cyc(8'h00, 32'h0, 0, 0, a, 0, 0, 1);
        d = b_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v; logic b;
        check("R1 word out", w_rdata, 32'h0);
        check("R1 bit out", {31'b0, b_rdata}, 32'h0);
        rd_word(8'h05, v); check("R1 word 5", v, 32'h0);
        rd_bit(8'h9F, b);  check("R1 bit 0.31", {31'b0, b}, 32'h0);
    endtask

    task automatic t_word_rw;
        logic [31:0] v;
        wr_word(8'h05, 32'h1234_5678);
        wr_word(8'h7F, 32'hCAFE_F00D);
        rd_word(8'h05, v); check("R2 word 5", v, 32'h1234_5678);
        rd_word(8'h7F, v); check("R2 word 127", v, 32'hCAFE_F00D);
    endtask

    task automatic t_bit_alias;
        logic [31:0] v; logic b;
        cyc(8'h00, 0, 0, 0, 8'hA3, 1, 1, 0);        // dw1 bit3 := 1
        rd_word(8'h01, v); check("R3 bit write seen in word", v, 32'h0000_0008);
        rd_bit(8'hA3, b);  check("R3 bit readback", {31'b0, b}, 32'h1);
        wr_word(8'h00, 32'hA5A5_0F0F);
        rd_bit(8'h80, b);  check("R3 word bit 0.0", {31'b0, b}, 32'h1);
        rd_bit(8'h84, b);  check("R3 word bit 0.4", {31'b0, b}, 32'h0);
    endtask

    task automatic t_word_port_bits;
        logic [31:0] v;
        rd_word(8'h81, v); check("R4 word port bit read", v, 32'h0000_0001);
        rd_word(8'h9F, v); check("R4 word port bit 0.31", v, 32'h0000_0001);
        wr_word(8'h9F, 32'hFFFF_FFFE);              // bit 0.31 := 0
        rd_word(8'h00, v); check("R4 word port bit write", v, 32'h25A5_0F0F);
    endtask

    task automatic t_range;
        logic [31:0] v; logic b;
        cyc(8'h00, 0, 0, 0, 8'hC1, 1, 1, 0);
        wr_word(8'hE5, 32'h0000_0001);
        rd_word(8'h00, v); check("R5 dw0 untouched", v, 32'h25A5_0F0F);
        rd_word(8'h01, v); check("R5 dw1 untouched", v, 32'h0000_0008);
        rd_word(8'h02, v); check("R5 dw2 untouched", v, 32'h0);
        rd_bit(8'hC1, b);  check("R5 bit read zero", {31'b0, b}, 32'h0);
        rd_word(8'hE5, v); check("R5 word port read zero", v, 32'h0);
    endtask

    task automatic t_bitport_wordview;
        logic [31:0] v; logic b;
        rd_bit(8'h05, b); check("R6 bit port reads LSB", {31'b0, b}, 32'h0);
        cyc(8'h00, 0, 0, 0, 8'h05, 1, 1, 0);
        rd_word(8'h05, v); check("R6 bit port writes LSB", v, 32'h1234_5679);
    endtask

    task automatic t_hold;
        logic [31:0] v;
        rd_word(8'h05, v);
        cyc(8'h7F, 32'h0, 1, 0, 8'h00, 0, 0, 0);
        check("R7 hold without enable", w_rdata, 32'h1234_5679);
    endtask

    task automatic t_read_old;
        logic [31:0] v;
        cyc(8'h09, 32'hDEAD_BEEF, 1, 1, 8'h00, 0, 0, 0);
        check("R8 read returns old", w_rdata, 32'h0);
        rd_word(8'h09, v); check("R8 new value after", v, 32'hDEAD_BEEF);
    endtask

    task automatic t_collide;
        logic [31:0] v;
        cyc(8'h01, 32'h0000_00F0, 1, 0, 8'hA4, 0, 1, 0);
        rd_word(8'h01, v); check("R9 bit clears word bit", v, 32'h0000_00E0);
        cyc(8'h00, 32'h0000_0000, 1, 0, 8'h82, 1, 1, 0);
        rd_word(8'h00, v); check("R9 bit sets other bit", v, 32'h0000_0004);
    endtask

    task automatic t_parallel;
        logic [31:0] v;
        cyc(8'h10, 32'h5555_AAAA, 1, 0, 8'h09, 0, 0, 1);
        check("R10 bit read during word write", {31'b0, b_rdata}, 32'h1);
        rd_word(8'h10, v); check("R10 word write done", v, 32'h5555_AAAA);
    endtask

    initial begin
        rst = 1; w_addr = 0; w_wdata = 0; w_we = 0; w_re = 0;
        b_addr = 0; b_wdata = 0; b_we = 0; b_re = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_word_rw();
        t_bit_alias();
        t_word_port_bits();
        t_range();
        t_bitport_wordview();
        t_hold();
        t_read_old();
        t_collide();
        t_parallel();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule